// File: doc/BRIEF.md
# Character LCD Parallel Host Port

This block is the register port that a microcontroller sees on a character LCD controller. It watches a register-select line, a read/write line, a transfer strobe and an 8-bit data bus that can be narrowed to a 4-bit mode. Writes go either to a write-only command register or to the data register. Reads return either a status word, made of the busy flag and the address counter, or a byte held in a data register.

A transfer opens when the strobe rises. The select lines are latched on that rising edge. Data is taken in, or the driven byte is released, when the strobe falls. When the port drives the bus, it also raises an output-enable signal.

Completed command writes, data writes and data reads reach the controller core as one-cycle strobes. The core answers with a busy signal, the current address counter and the RAM byte at that address. After every access other than a status read, the data register is reloaded from the RAM byte once the core is no longer busy. A data read therefore always returns a byte that was fetched before the read began. After a synchronous reset, the port reports busy for a fixed number of initialisation cycles.

Top module: `lcd_host_port`

## Requirements
- R1: A write with `rs_i`=0 delivers the byte on `instr_o` with a single `instr_stb_o` pulse, and `dwr_stb_o` stays low.
- R2: A write with `rs_i`=1 delivers the byte on `dwr_o` with a single `dwr_stb_o` pulse, and `instr_stb_o` stays low.
- R3: A read with `rs_i`=0 returns the status word: the busy flag on bit 7 and `ac_i` on bits 6..0. The command byte that was written is never returned.
- R4: A read with `rs_i`=1 returns the data register and pulses `drd_stb_o`. After every command write, data write or data read, the data register is reloaded from `ram_rdata_i` once the port is no longer busy.
- R5: `db_oe_o` is high only while the strobe is high in a transfer latched with `rw_i`=1. While `db_oe_o` is low, `db_o` is 0.
- R6: With `bus4_mode_i`=1, a byte is written over two strobe cycles, high nibble first, each nibble taken from `db_i[7:4]`. `db_i[3:0]` is ignored, and the strobe for the byte pulses only after the second nibble.
- R7: With `bus4_mode_i`=1, a read presents the high nibble and then the low nibble on `db_o[7:4]`, with `db_o[3:0]`=0.
- R8: While busy (core busy or initialisation), command writes and data writes are dropped with no strobe, and status reads are still served.
- R9: After reset, the busy flag stays set for `INIT_CYC` cycles and then follows `core_busy_i`.
- R10: Reset returns the 4-bit nibble phase to the high nibble. A half-finished byte is discarded.
- R11: Each completed byte produces exactly one strobe pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus4_mode_i | input | 1 | 1 selects the 4-bit bus on db bits 7..4 |
| rs_i | input | 1 | Register select: 0 command/status, 1 data |
| rw_i | input | 1 | 1 read, 0 write |
| en_i | input | 1 | Transfer strobe |
| db_i | input | 8 | Bus value driven by the host |
| db_o | output | 8 | Bus value driven by the port |
| db_oe_o | output | 1 | Port drives the bus when high |
| core_busy_i | input | 1 | Core is still processing |
| ac_i | input | 7 | Core address counter |
| ram_rdata_i | input | 8 | RAM byte at the address counter |
| instr_stb_o | output | 1 | Command byte valid pulse |
| instr_o | output | 8 | Command byte |
| dwr_stb_o | output | 1 | Data write pulse |
| dwr_o | output | 8 | Data write byte |
| drd_stb_o | output | 1 | Data read completed pulse |

## Verification
All timing is counted from the clock edges at which the strobe is first seen high and then seen low. Read data and `db_oe_o` become valid one clock after the strobe is seen high. The strobes to the core pulse during the cycle after the edge at which the strobe is seen low. A data-register refill lands two clocks after that pulse if the port is not busy. The bench records strobes on every rising edge and samples read results on the falling clock edge after two rising edges of a high strobe. It also holds four idle clocks after each transfer before judging counts, so that strobes and refills are never sampled early.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int AC_W   = BYTE_W - 1;

  typedef enum logic {NIB_HI = 1'b0, NIB_LO = 1'b1} nib_phase_e;

  function automatic logic [BYTE_W-1:0] join_nibbles(input logic [NIB_W-1:0] hi,
                                                     input logic [NIB_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [BYTE_W-1:0] status_word(input logic bf,
                                                    input logic [AC_W-1:0] ac);
    return {bf, ac};
  endfunction

  // Moves the nibble selected by the phase to the upper bus half, lower half zero.
  function automatic logic [BYTE_W-1:0] place_nibble(input logic [BYTE_W-1:0] b,
                                                     input nib_phase_e ph);
    if (ph == NIB_HI) return {b[BYTE_W-1:NIB_W], {NIB_W{1'b0}}};
    else              return {b[NIB_W-1:0],      {NIB_W{1'b0}}};
  endfunction
endpackage

// File: rtl/lcdp_edge.sv
module lcdp_edge (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic rs_i,
  input  logic rw_i,
  output logic en_q_o,
  output logic fall_o,
  output logic cyc_rs_o,
  output logic cyc_rw_o
);
  logic rise_w;
  assign rise_w = en_i & ~en_q_o;
  assign fall_o = en_q_o & ~en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q_o   <= 1'b0;
      cyc_rs_o <= 1'b0;
      cyc_rw_o <= 1'b0;
    end else begin
      en_q_o <= en_i;
      if (rise_w) begin
        cyc_rs_o <= rs_i;
        cyc_rw_o <= rw_i;
      end
    end
  end
endmodule

// File: rtl/lcdp_nibble.sv
module lcdp_nibble
  import lcdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mode4_i,
  input  logic              fall_i,
  input  logic [BYTE_W-1:0] din_i,
  output nib_phase_e        phase_o,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o <= NIB_HI;
      hi_q    <= '0;
    end else if (!mode4_i) begin
      phase_o <= NIB_HI;
    end else if (fall_i) begin
      phase_o <= (phase_o == NIB_HI) ? NIB_LO : NIB_HI;
      if (phase_o == NIB_HI) hi_q <= din_i[BYTE_W-1:NIB_W];
    end
  end

  assign byte_done_o = fall_i & (~mode4_i | (phase_o == NIB_LO));
  assign byte_o      = mode4_i ? join_nibbles(hi_q, din_i[BYTE_W-1:NIB_W]) : din_i;

  AST_PHASE_PAIR: assert property (@(posedge clk) disable iff (rst)
    (fall_i && mode4_i && phase_o == NIB_HI) |=> (phase_o == NIB_LO)); // R6
  AST_PHASE_RESET: assert property (@(posedge clk)
    $past(rst) |-> (phase_o == NIB_HI)); // R10
endmodule

// File: rtl/lcdp_init_busy.sv
module lcdp_init_busy #(
  parameter int INIT_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic core_busy_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(INIT_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= CNT_W'(INIT_CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0) | core_busy_i;

  AST_INIT_BUSY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busy_o); // R9
endmodule

// File: rtl/lcdp_read_path.sv
module lcdp_read_path
  import lcdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              refill_req_i,
  input  logic [BYTE_W-1:0] ram_rdata_i,
  input  logic              sel_data_i,
  input  logic [AC_W-1:0]   ac_i,
  input  logic              mode4_i,
  input  nib_phase_e        phase_i,
  input  logic              oe_i,
  output logic [BYTE_W-1:0] db_o
);
  logic [BYTE_W-1:0] dr_q;
  logic              pend_q;
  logic [BYTE_W-1:0] word_w;
  logic              load_w;

  assign load_w = pend_q & ~busy_i & ~refill_req_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      dr_q   <= '0;
      pend_q <= 1'b1;
    end else if (refill_req_i) begin
      pend_q <= 1'b1;
    end else if (load_w) begin
      dr_q   <= ram_rdata_i;
      pend_q <= 1'b0;
    end
  end

  assign word_w = sel_data_i ? dr_q : status_word(busy_i, ac_i);

  always_comb begin
    if (!oe_i)        db_o = '0;
    else if (mode4_i) db_o = place_nibble(word_w, phase_i);
    else              db_o = word_w;
  end

  AST_DR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(pend_q)) |-> $stable(dr_q)); // R4
  AST_LO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (oe_i && mode4_i) |-> (db_o[NIB_W-1:0] == '0)); // R7
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
  import lcdp_pkg::*;
#(
  parameter int INIT_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus4_mode_i,
  input  logic              rs_i,
  input  logic              rw_i,
  input  logic              en_i,
  input  logic [BYTE_W-1:0] db_i,
  output logic [BYTE_W-1:0] db_o,
  output logic              db_oe_o,
  input  logic              core_busy_i,
  input  logic [AC_W-1:0]   ac_i,
  input  logic [BYTE_W-1:0] ram_rdata_i,
  output logic              instr_stb_o,
  output logic [BYTE_W-1:0] instr_o,
  output logic              dwr_stb_o,
  output logic [BYTE_W-1:0] dwr_o,
  output logic              drd_stb_o
);
  logic              en_q_w, fall_w, cyc_rs_w, cyc_rw_w;
  nib_phase_e        phase_w;
  logic              byte_done_w;
  logic [BYTE_W-1:0] byte_w;
  logic              busy_w;
  logic              wr_ok_w;
  logic              refill_w;

  lcdp_edge u_edge (
    .clk(clk), .rst(rst), .en_i(en_i), .rs_i(rs_i), .rw_i(rw_i),
    .en_q_o(en_q_w), .fall_o(fall_w), .cyc_rs_o(cyc_rs_w), .cyc_rw_o(cyc_rw_w)
  );

  lcdp_nibble u_nib (
    .clk(clk), .rst(rst), .mode4_i(bus4_mode_i), .fall_i(fall_w), .din_i(db_i),
    .phase_o(phase_w), .byte_done_o(byte_done_w), .byte_o(byte_w)
  );

  lcdp_init_busy #(.INIT_CYC(INIT_CYC)) u_busy (
    .clk(clk), .rst(rst), .core_busy_i(core_busy_i), .busy_o(busy_w)
  );

  assign db_oe_o  = en_q_w & cyc_rw_w;
  assign wr_ok_w  = byte_done_w & ~cyc_rw_w & ~busy_w;
  assign refill_w = instr_stb_o | dwr_stb_o | drd_stb_o;

  lcdp_read_path u_rd (
    .clk(clk), .rst(rst), .busy_i(busy_w), .refill_req_i(refill_w),
    .ram_rdata_i(ram_rdata_i), .sel_data_i(cyc_rs_w), .ac_i(ac_i),
    .mode4_i(bus4_mode_i), .phase_i(phase_w), .oe_i(db_oe_o), .db_o(db_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_stb_o <= 1'b0;
      dwr_stb_o   <= 1'b0;
      drd_stb_o   <= 1'b0;
      instr_o     <= '0;
      dwr_o       <= '0;
    end else begin
      instr_stb_o <= wr_ok_w & ~cyc_rs_w;
      dwr_stb_o   <= wr_ok_w &  cyc_rs_w;
      drd_stb_o   <= byte_done_w & cyc_rw_w & cyc_rs_w;
      if (wr_ok_w && !cyc_rs_w) instr_o <= byte_w;
      if (wr_ok_w &&  cyc_rs_w) dwr_o   <= byte_w;
    end
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(instr_stb_o && dwr_stb_o)); // R1
  AST_OE_STROBE: assert property (@(posedge clk) disable iff (rst)
    db_oe_o |-> $past(en_i)); // R5
  AST_OE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !db_oe_o |-> (db_o == '0)); // R5
  AST_NO_INSTR_BUSY: assert property (@(posedge clk) disable iff (rst)
    instr_stb_o |-> !$past(busy_w)); // R8
  AST_NO_DWR_BUSY: assert property (@(posedge clk) disable iff (rst)
    dwr_stb_o |-> !$past(busy_w)); // R8
  AST_INSTR_PULSE: assert property (@(posedge clk) disable iff (rst)
    instr_stb_o |=> !instr_stb_o); // R11
  AST_DWR_PULSE: assert property (@(posedge clk) disable iff (rst)
    dwr_stb_o |=> !dwr_stb_o); // R2
endmodule

// File: tb/lcd_host_port_tb.sv
module lcd_host_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode4 = 1'b0, rs = 1'b0, rw = 1'b0, en = 1'b0, cbusy = 1'b0;
  logic [7:0] din = 8'h00, ram = 8'h5A;
  logic [6:0] ac = 7'h15;
  logic [7:0] db_o, instr_o, dwr_o;
  logic       db_oe_o, instr_stb_o, dwr_stb_o, drd_stb_o;

  int n_chk = 0, n_bad = 0;
  int n_instr = 0, n_dwr = 0, n_drd = 0;
  logic [7:0] last_instr = 8'h00, last_dwr = 8'h00;
  logic [7:0] rd_val;
  logic       oe_val;

  localparam int INIT = 16;

  always #4 clk = ~clk;

  lcd_host_port #(.INIT_CYC(INIT)) u_dut (
    .clk(clk), .rst(rst), .bus4_mode_i(mode4), .rs_i(rs), .rw_i(rw), .en_i(en),
    .db_i(din), .db_o(db_o), .db_oe_o(db_oe_o), .core_busy_i(cbusy), .ac_i(ac),
    .ram_rdata_i(ram), .instr_stb_o(instr_stb_o), .instr_o(instr_o),
    .dwr_stb_o(dwr_stb_o), .dwr_o(dwr_o), .drd_stb_o(drd_stb_o)
  );

  always @(posedge clk) begin
    if (instr_stb_o) begin n_instr++; last_instr = instr_o; end
    if (dwr_stb_o)   begin n_dwr++;   last_dwr   = dwr_o;   end
    if (drd_stb_o)   n_drd++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // One strobe cycle; returns the bus value and enable seen while the strobe is high.
  task automatic bus_cycle(input logic r_s, input logic r_w, input logic [7:0] d);
    @(posedge clk); #1;
    rs = r_s; rw = r_w; din = d; en = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd_val = db_o; oe_val = db_oe_o;
    @(posedge clk); #1 en = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check("R5 oe after reset", db_oe_o, 0);
    check("R5 bus after reset", db_o, 0);
    bus_cycle(1'b0, 1'b1, 8'h00);
    check("R9 busy during init", rd_val, 8'h95);
    check("R5 oe on read", oe_val, 1);
    @(negedge clk);
    check("R5 oe after strobe falls", db_oe_o, 0);
    repeat (INIT + 4) @(posedge clk);
    bus_cycle(1'b0, 1'b1, 8'h00);
    check("R9 busy cleared after init", rd_val, 8'h15);
  endtask

  task automatic t_instr_write();
    int n0 = n_instr, d0 = n_dwr;
    bus_cycle(1'b0, 1'b0, 8'h38);
    check("R5 no drive on write", oe_val, 0);
    check("R1 instr strobe count", n_instr - n0, 1);
    check("R11 single pulse", n_instr - n0, 1);
    check("R1 instr byte", last_instr, 8'h38);
    check("R1 no data strobe", n_dwr - d0, 0);
    bus_cycle(1'b0, 1'b1, 8'h00);
    check("R3 status not command", rd_val, 8'h15);
  endtask

  task automatic t_data_rw();
    int n0 = n_dwr, i0 = n_instr, r0 = n_drd;
    bus_cycle(1'b1, 1'b0, 8'hA5);
    check("R2 data strobe count", n_dwr - n0, 1);
    check("R2 data byte", last_dwr, 8'hA5);
    check("R2 no instr strobe", n_instr - i0, 0);
    ram = 8'hC3;
    bus_cycle(1'b1, 1'b1, 8'h00);
    check("R4 data read prefetched", rd_val, 8'h5A);
    check("R4 read strobe", n_drd - r0, 1);
    bus_cycle(1'b1, 1'b1, 8'h00);
    check("R4 refill after read", rd_val, 8'hC3);
  endtask

  task automatic t_busy_drop();
    int i0 = n_instr, d0 = n_dwr;
    cbusy = 1'b1;
    bus_cycle(1'b0, 1'b0, 8'h01);
    bus_cycle(1'b1, 1'b0, 8'h77);
    check("R8 instr dropped", n_instr - i0, 0);
    check("R8 data dropped", n_dwr - d0, 0);
    bus_cycle(1'b0, 1'b1, 8'h00);
    check("R8 status while busy", rd_val, 8'h95);
    cbusy = 1'b0;
  endtask

  task automatic t_nib_write();
    int i0 = n_instr;
    mode4 = 1'b1;
    bus_cycle(1'b0, 1'b0, 8'h4F);
    check("R6 no strobe after high nibble", n_instr - i0, 0);
    bus_cycle(1'b0, 1'b0, 8'h2B);
    check("R6 strobe after low nibble", n_instr - i0, 1);
    check("R6 nibbles joined, low bits ignored", last_instr, 8'h42);
  endtask

  task automatic t_nib_read();
    bus_cycle(1'b0, 1'b1, 8'hFF);
    check("R7 status high nibble", rd_val, 8'h10);
    bus_cycle(1'b0, 1'b1, 8'hFF);
    check("R7 status low nibble", rd_val, 8'h50);
    bus_cycle(1'b1, 1'b1, 8'hFF);
    check("R7 data high nibble", rd_val, 8'hC0);
    bus_cycle(1'b1, 1'b1, 8'hFF);
    check("R7 data low nibble", rd_val, 8'h30);
  endtask

  task automatic t_nib_reset();
    int i0;
    bus_cycle(1'b0, 1'b0, 8'h90);
    do_reset();
    repeat (INIT + 4) @(posedge clk);
    i0 = n_instr;
    bus_cycle(1'b0, 1'b0, 8'h30);
    bus_cycle(1'b0, 1'b0, 8'h70);
    check("R10 one strobe after reset", n_instr - i0, 1);
    check("R10 phase restarts high", last_instr, 8'h37);
    mode4 = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_instr_write();
    t_data_rw();
    t_busy_drop();
    t_nib_write();
    t_nib_read();
    t_nib_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule